// File: doc/BRIEF.md
# Programmable Interval Timer Counter

A single-channel 16-bit timer that sits behind a small word-addressed register bus. It advances on the bus clock, either on every cycle or through a power-of-two prescaler. It can count up or down. In interval mode it wraps at a programmed limit. Three compare registers can flag the cycle in which the count lands on their value.

A sticky status register records five kinds of event: interval wrap, the three compare hits, and full-range overflow. Each status bit has a matching enable bit, and together they drive one combined interrupt line. A waveform pin toggles on hits of the first compare register and has a selectable polarity. A counter-reset control bit reloads the count and then clears itself.

Software stops the counter, programs the limit, prescaler and compares, clears stale status, and then releases the counter.

Top module: `pit_counter`

## Requirements
- R1: After reset, the control word reads 0x21 (counter stopped, waveform off). The count, status, enables, clock control and interval read 0, and `irq_o` and `wave_o` are 0.
- R2: An access is held with `bus_sel` high. `bus_ready` rises one cycle after select and stays high for one cycle. A write takes effect on the clock edge where `bus_ready` is high. Read data is valid while `bus_ready` is high. Word addresses are:
  - 0: clock control
  - 1: control
  - 2: count (read-only)
  - 3: interval
  - 4, 5, 6: compare 0, 1, 2
  - 7: status
  - 8: enable

  Control bit 0 set stops the counter, which then holds its value. With bit 0 clear and the prescaler off, the count changes by one on every clock edge after the edge that wrote the control word.
- R3: Clock control bit 0 turns on the prescaler, and bits 4:1 hold an exponent N. While the prescaler is on, the counter takes one step every 2^(N+1) clocks, starting from the edge that started the counter.
- R4: Writing control bit 4 as 1 reloads the count in the same edge. The reload value is 0 when counting up, or the interval value when bit 2 (count down) is set in the same write. Bit 4 reads back as 0 from the following cycle.
- R5: With control bit 1 (interval mode) set and counting up, the count goes from the interval value to 0, and status bit 0 is set.
- R6: With interval mode set and control bit 2 set (counting down), the count goes from 0 to the interval value, and status bit 0 is set.
- R7: Outside interval mode, the count wraps between 0xFFFF and 0 in either direction, and status bit 4 is set.
- R8: Status bits stay set until software clears them. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: `irq_o` is high exactly when some status bit and the same enable bit are both 1.
- R10: With control bit 3 set, a counter step that lands on the value of compare register i sets status bit i+1.
- R11: `wave_o` is 0 while control bit 5 is 1. Otherwise it shows an internal level that toggles on each compare 0 hit; the level starts at 0 and is inverted when control bit 6 is 1.
- R12: A counter-reset write that falls on the same edge as a counter step wins. The count takes the reload value, and that step is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ready |
| bus_ready | output | 1 | One-cycle access completion |
| irq_o | output | 1 | Combined interrupt |
| wave_o | output | 1 | Waveform output |

## Verification
A counter-reset write can land on the same clock edge as a counter step, because the counter keeps running while the control word is rewritten. The bench provokes this by writing the reset bit while the counter is running in interval mode. It records the edge of that write and the edge of the later stop write. It then expects the count to equal the number of edges in between, taken modulo the interval length. If the step survived the reset, the count would be one higher, so the read exposes the lost step.

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int PW = 4,
  parameter int NM = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ready,
  output logic          irq_o,
  output logic          wave_o
);
  localparam int NI    = NM + 2;
  localparam int PRW   = (1 << PW) + 1;
  localparam int A_CLK = 0;
  localparam int A_CTL = 1;
  localparam int A_CNT = 2;
  localparam int A_IVL = 3;
  localparam int A_M0  = 4;
  localparam int A_STS = A_M0 + NM;
  localparam int A_IEN = A_STS + 1;

  logic [PW:0]            clk_q;
  logic [6:0]             ctl_q;
  logic [CW-1:0]          cnt_q, ivl_q, nxt;
  logic [NM-1:0][CW-1:0]  mat_q;
  logic [NI-1:0]          sts_q, ien_q, sts_set;
  logic [NM-1:0]          mhit;
  logic [PRW-1:0]         pre_q, pre_lim;
  logic                   wave_q, wrap_i, ovf, tick, tk;
  logic [DW-1:0]          rd_mux;

  wire wr     = bus_sel & bus_wr & bus_ready;
  wire wr_ctl = wr && bus_addr == AW'(A_CTL);
  wire wr_sts = wr && bus_addr == AW'(A_STS);
  wire rw     = wr_ctl & bus_wdata[4];
  wire run    = ~ctl_q[0];

  assign pre_lim = (PRW'(2) << clk_q[PW:1]) - PRW'(1);
  assign tick    = run & (~clk_q[0] | (pre_q == pre_lim));
  assign tk      = tick & ~rw;

  always_comb begin
    nxt = cnt_q; wrap_i = 1'b0; ovf = 1'b0;
    if (!ctl_q[2]) begin
      if (ctl_q[1] && cnt_q == ivl_q) begin nxt = '0; wrap_i = 1'b1; end
      else if (cnt_q == '1)           begin nxt = '0; ovf = 1'b1; end
      else                            nxt = cnt_q + 1'b1;
    end else begin
      if (ctl_q[1] && cnt_q == '0)    begin nxt = ivl_q; wrap_i = 1'b1; end
      else if (cnt_q == '0)           begin nxt = '1; ovf = 1'b1; end
      else                            nxt = cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < NM; i++) begin : g_cmp
    assign mhit[i] = tk & ctl_q[3] & (nxt == mat_q[i]);
  end

  assign sts_set = {ovf & tk, mhit, wrap_i & tk};
  assign irq_o   = |(sts_q & ien_q);
  assign wave_o  = ~ctl_q[5] & (wave_q ^ ctl_q[6]);

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(A_CLK)) rd_mux[PW:0] = clk_q;
    if (bus_addr == AW'(A_CTL)) rd_mux[6:0]  = ctl_q;
    if (bus_addr == AW'(A_CNT)) rd_mux[CW-1:0] = cnt_q;
    if (bus_addr == AW'(A_IVL)) rd_mux[CW-1:0] = ivl_q;
    for (int i = 0; i < NM; i++)
      if (bus_addr == AW'(A_M0 + i)) rd_mux[CW-1:0] = mat_q[i];
    if (bus_addr == AW'(A_STS)) rd_mux[NI-1:0] = sts_q;
    if (bus_addr == AW'(A_IEN)) rd_mux[NI-1:0] = ien_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_sel & ~bus_ready;
      if (bus_sel && !bus_ready && !bus_wr) bus_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q <= '0;
      ctl_q <= 7'h21;
      ivl_q <= '0;
      mat_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_ctl) ctl_q <= bus_wdata[6:0];
      else        ctl_q[4] <= 1'b0;
      if (wr && bus_addr == AW'(A_CLK)) clk_q <= bus_wdata[PW:0];
      if (wr && bus_addr == AW'(A_IVL)) ivl_q <= bus_wdata[CW-1:0];
      if (wr && bus_addr == AW'(A_IEN)) ien_q <= bus_wdata[NI-1:0];
      for (int i = 0; i < NM; i++)
        if (wr && bus_addr == AW'(A_M0 + i)) mat_q[i] <= bus_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= '0;
      sts_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      if (rw)        cnt_q <= bus_wdata[2] ? ivl_q : '0;
      else if (tick) cnt_q <= nxt;
      if (!run || !clk_q[0] || rw || pre_q == pre_lim) pre_q <= '0;
      else                                            pre_q <= pre_q + 1'b1;
      sts_q <= (sts_q & ~(wr_sts ? bus_wdata[NI-1:0] : '0)) | sts_set;
      if (mhit[0]) wave_q <= ~wave_q;
    end
  end

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready); // R2
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[0] && !wr_ctl) |=> $stable(cnt_q)); // R2
  AST_RESET_BIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[4] && !wr_ctl) |=> !ctl_q[4]); // R4
  AST_INTERVAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[1] && cnt_q <= ivl_q && !wr) |=> cnt_q <= ivl_q); // R5
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sts |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R8
endmodule

// File: tb/pit_counter_tb.sv
module pit_counter_tb_top;
  localparam int A_CLK = 0, A_CTL = 1, A_CNT = 2, A_IVL = 3;
  localparam int A_M0 = 4, A_M1 = 5, A_M2 = 6, A_STS = 7, A_IEN = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, irq_o, wave_o;

  int n_cmp = 0, n_bad = 0, cyc = 0, last_e = 0;

  typedef struct { bit is_rd; logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  pit_counter dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq_o(irq_o), .wave_o(wave_o)
  );

  always #5ns clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && bus_ready) begin
      if (sbq.size() == 0) begin
        n_bad++;
        $display("FAIL R2: ready without pending access, actual 1 expected 0");
      end else begin
        item_t it;
        it = sbq.pop_front();
        if (it.is_rd) begin
          n_cmp++;
          if (bus_rdata !== it.exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, bus_rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    item_t it;
    it.is_rd = 1'b0; it.exp = '0; it.tag = "";
    sbq.push_back(it);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    last_e = cyc;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_rd = 1'b1; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(a);
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int e0, e1, er, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_o, 1'b0, "R1 irq after reset");
    chk(wave_o, 1'b0, "R1 wave after reset");
    rd(A_CTL, 32'h21, "R1 control reset");
    rd(A_CNT, 0, "R1 count reset");
    rd(A_STS, 0, "R1 status reset");
    rd(A_CLK, 0, "R1 clock control reset");

    // R2 free running up count
    wr(A_CTL, 32'h20); e0 = last_e;
    repeat (20) @(posedge clk);
    wr(A_CTL, 32'h21); e1 = last_e;
    rd(A_CNT, 32'(e1 - e0), "R2 up count");

    // R4 reset bit and self clear
    wr(A_CTL, 32'h31);
    rd(A_CNT, 0, "R4 reload up");
    rd(A_CTL, 32'h21, "R4 bit self-clears");

    // R3 prescaler N=1 and N=2
    wr(A_CLK, 32'h3);
    wr(A_CTL, 32'h20); e0 = last_e;
    repeat (37) @(posedge clk);
    wr(A_CTL, 32'h21); e1 = last_e;
    rd(A_CNT, 32'((e1 - e0) / 4), "R3 prescale div4");
    wr(A_CTL, 32'h31);
    wr(A_CLK, 32'h5);
    wr(A_CTL, 32'h20); e0 = last_e;
    repeat (61) @(posedge clk);
    wr(A_CTL, 32'h21); e1 = last_e;
    rd(A_CNT, 32'((e1 - e0) / 8), "R3 prescale div8");
    wr(A_CLK, 0);

    // R5 interval wrap counting up
    wr(A_IVL, 5);
    wr(A_CTL, 32'h31);
    wr(A_STS, 32'h1F);
    wr(A_CTL, 32'h22); e0 = last_e;
    repeat (15) @(posedge clk);
    wr(A_CTL, 32'h23); e1 = last_e;
    t = e1 - e0;
    rd(A_CNT, 32'(t % 6), "R5 interval up count");
    rd(A_STS, (t >= 6) ? 32'h1 : 32'h0, "R5 interval status");

    // R12 reset write on a counting edge
    wr(A_CTL, 32'h22);
    repeat (4) @(posedge clk);
    wr(A_CTL, 32'h32); er = last_e;
    repeat (7) @(posedge clk);
    wr(A_CTL, 32'h23); e1 = last_e;
    rd(A_CNT, 32'((e1 - er) % 6), "R12 reset beats step");

    // R6 interval reload counting down
    wr(A_CTL, 32'h17);
    rd(A_CNT, 5, "R4 reload down");
    wr(A_STS, 32'h1F);
    wr(A_CTL, 32'h06); e0 = last_e;
    repeat (20) @(posedge clk);
    wr(A_CTL, 32'h07); e1 = last_e;
    t = e1 - e0;
    rd(A_CNT, 32'(5 - (t % 6)), "R6 interval down count");
    rd(A_STS, 32'h1, "R6 interval status");

    // R7 overflow outside interval mode
    wr(A_IVL, 3);
    wr(A_CTL, 32'h15);
    wr(A_STS, 32'h1F);
    wr(A_CTL, 32'h04); e0 = last_e;
    repeat (10) @(posedge clk);
    wr(A_CTL, 32'h05); e1 = last_e;
    t = e1 - e0;
    rd(A_CNT, 32'((3 - t) & 32'hFFFF), "R7 down wrap count");
    rd(A_STS, 32'h10, "R7 overflow status");

    // R8 write-one-to-clear
    wr(A_STS, 32'h0F);
    rd(A_STS, 32'h10, "R8 zero bits keep status");
    wr(A_STS, 32'h10);
    rd(A_STS, 32'h0, "R8 one clears status");

    // R10 / R11 compare hits and waveform
    wr(A_M0, 3); wr(A_M1, 100); wr(A_M2, 7);
    wr(A_CTL, 32'h31);
    wr(A_STS, 32'h1F);
    wr(A_CTL, 32'h08); e0 = last_e;
    repeat (8) @(posedge clk);
    wr(A_CTL, 32'h09); e1 = last_e;
    t = e1 - e0;
    rd(A_STS, ((t >= 3) ? 32'h2 : 0) | ((t >= 100) ? 32'h4 : 0) | ((t >= 7) ? 32'h8 : 0),
       "R10 compare status");
    chk(wave_o, 1'b1, "R11 wave after one hit");
    wr(A_CTL, 32'h49);
    chk(wave_o, 1'b0, "R11 inverted polarity");
    wr(A_CTL, 32'h29);
    chk(wave_o, 1'b0, "R11 wave disabled");

    // R9 combined interrupt
    chk(irq_o, 1'b0, "R9 no enables");
    wr(A_IEN, 32'h02);
    chk(irq_o, 1'b1, "R9 enabled compare status");
    wr(A_IEN, 32'h01);
    chk(irq_o, 1'b0, "R9 enabled bit clear");
    wr(A_IEN, 32'h02);
    wr(A_STS, 32'h02);
    chk(irq_o, 1'b0, "R9 status cleared");

    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      n_bad++;
      $display("FAIL R2: pending accesses actual %0d expected 0", sbq.size());
    end
    finish_run();
  end
endmodule